// File: doc/BRIEF.md
# Single-wire bus receive conditioner

This block sits between the receive comparators of a single-wire bus transceiver and the receive-data pin that goes to the bus controller. It takes two already-digitized comparator levels: one for normal dominant signalling and one for the high-voltage wake-up level. From these it builds three outputs: the receive-data value, an enable that models whether that pin is driven, and a qualified wake-up flag. Bus pulses shorter than a minimum length are absorbed by a restartable glitch filter. For a window after the local transmitter releases the bus, which is a rising edge on the transmit-data input, the output is forced recessive so that bus ringing never reaches the controller.

A four-state controller chooses what the pin shows. `ST_SLEEP` leaves the pin undriven. `ST_WAKEIRQ` drives it low as a wake-up interrupt. `ST_PASS` passes the filtered bus level. `ST_BLANK` forces the recessive level.

The transitions are:
- *sleep entry*: `ST_PASS` or `ST_BLANK` to `ST_SLEEP` when the sleep flag is high.
- *wake qualify*: `ST_SLEEP` to `ST_WAKEIRQ` when the filtered wake flag is high.
- *resume*: `ST_SLEEP` or `ST_WAKEIRQ` to `ST_PASS` when the sleep flag drops.
- *release*: `ST_PASS` to `ST_BLANK` on a transmit rising edge.
- *re-release*: `ST_BLANK` stays in `ST_BLANK` and restarts its window on another rising edge.
- *window end*: `ST_BLANK` to `ST_PASS` on the last cycle of the window.

All lengths are counted in clock cycles and are set by parameters.

Top module: `swrx_rx_cond`

## Requirements
- R1: In `ST_PASS`, `rxd_o` is 0 while the filtered normal comparator (`bus_dom_i`, 1 = dominant) is dominant, and 1 while it is recessive.
- R2: A change on `bus_dom_i` reaches `rxd_o` only after the new level has been sampled on MIN_PULSE_CYC consecutive clock edges, so the latency is MIN_PULSE_CYC cycles. A pulse of MIN_PULSE_CYC-1 cycles has no effect.
- R3: The filter treats a dominant-to-recessive change exactly like a recessive-to-dominant change, so a recessive gap shorter than MIN_PULSE_CYC does not reach `rxd_o`.
- R4: One cycle after `tx_i` is sampled rising (0 then 1) in an awake state, `rxd_o` is forced to 1 for BLANK_CYC cycles, whatever the bus does. Afterwards it follows the filtered bus again.
- R5: A second rising edge of `tx_i` inside the window restarts the full BLANK_CYC window from that edge.
- R6: `wake_o` rises after `hv_dom_i` has been sampled high on WAKE_FILT_CYC consecutive edges, and falls WAKE_FILT_CYC cycles after `hv_dom_i` drops. A shorter high excursion leaves `wake_o` at 0.
- R7: One cycle after `sleep_i` is high, `rxd_oe_o` is 0 and `rxd_o` is 1, and normal bus traffic changes neither.
- R8: While asleep, one cycle after `wake_o` rises, `rxd_o` is driven 0 with `rxd_oe_o` = 1. It stays so for as long as `sleep_i` stays high, even after `hv_dom_i` returns low.
- R9: One cycle after `sleep_i` falls, `rxd_oe_o` is 1 and `rxd_o` follows the filtered bus.
- R10: During reset `rxd_o` = 1, `rxd_oe_o` = 0 and `wake_o` = 0, and both filters hold the recessive level.
- R11: Sleep takes priority over blanking. Leaving sleep enters `ST_PASS` directly, so a window that was cut short by sleep does not resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Transceiver is in its low-power mode |
| tx_i | input | 1 | Transmit data level (1 = recessive) |
| bus_dom_i | input | 1 | Normal-threshold comparator, 1 = bus dominant |
| hv_dom_i | input | 1 | High-voltage wake-up comparator, 1 = above wake level |
| rxd_o | output | 1 | Receive data to controller (0 = dominant or interrupt) |
| rxd_oe_o | output | 1 | 1 when `rxd_o` is driven, 0 when undriven |
| wake_o | output | 1 | Qualified wake-up detect |

## Verification
The bench drives dominant and recessive runs of exactly MIN_PULSE_CYC-1 and MIN_PULSE_CYC cycles in both directions. This separates an off-by-one in the filter length from a filter that only works on one edge. Transmit releases are applied with the bus still dominant, so a missing or shortened window shows up as a 0. A second release halfway through a window tells a restart apart from a window that is only extended. In sleep, wake excursions one cycle short of the filter time are compared with full-length ones, and a sleep request during a window shows whether blanking leaks past sleep.

// File: rtl/swrx_pkg.sv
package swrx_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_WAKEIRQ = 2'd1,
        ST_PASS    = 2'd2,
        ST_BLANK   = 2'd3
    } rx_state_t;

endpackage

// File: rtl/swrx_glitch_filter.sv
module swrx_glitch_filter #(
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          clean_q;

    // Restartable counter: any return to the held level clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= 1'b0;
        end else if (raw_i == clean_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            clean_q <= raw_i;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign clean_o = clean_q;

    // Independent run-length observer for the minimum-length check.
    logic [CW-1:0] run_q;
    logic          raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw_i;
            if (raw_i != raw_q)
                run_q <= CW'(1);
            else if (run_q < CW'(SETTLE_CYC))
                run_q <= run_q + CW'(1);
        end
    end

    // R2 (bus filter instance) and R6 (wake filter instance)
    assert_min_run_R2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_q != $past(clean_q)) |-> (run_q >= CW'(SETTLE_CYC) && raw_q == clean_q));

endmodule

// File: rtl/swrx_blank_timer.sv
module swrx_blank_timer #(
    parameter int unsigned BLANK_CYC = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_i,
    output logic rise_o,
    output logic last_o
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1);

    logic          tx_q;
    logic [BW-1:0] left_q;

    assign rise_o = tx_i & ~tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= 1'b1;
            left_q <= '0;
        end else begin
            tx_q <= tx_i;
            if (rise_o)
                left_q <= BW'(BLANK_CYC);
            else if (left_q != '0)
                left_q <= left_q - BW'(1);
        end
    end

    assign last_o = (left_q == BW'(1));

endmodule

// File: rtl/swrx_out_fsm.sv
module swrx_out_fsm
    import swrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic rise_i,
    input  logic last_i,
    input  logic dom_i,
    input  logic wake_i,
    output logic rxd_o,
    output logic oe_o
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (!sleep_i)     state_d = ST_PASS;      // resume
                else if (wake_i)  state_d = ST_WAKEIRQ;   // wake qualify
            end
            ST_WAKEIRQ: begin
                if (!sleep_i)     state_d = ST_PASS;      // resume
            end
            ST_PASS: begin
                if (sleep_i)      state_d = ST_SLEEP;     // sleep entry
                else if (rise_i)  state_d = ST_BLANK;     // release
            end
            ST_BLANK: begin
                if (sleep_i)      state_d = ST_SLEEP;     // sleep entry
                else if (rise_i)  state_d = ST_BLANK;     // re-release
                else if (last_i)  state_d = ST_PASS;      // window end
            end
        endcase
    end

    always_comb begin
        rxd_o = 1'b1;
        oe_o  = 1'b1;
        unique case (state_q)
            ST_SLEEP:   begin rxd_o = 1'b1;   oe_o = 1'b0; end
            ST_WAKEIRQ: begin rxd_o = 1'b0;   oe_o = 1'b1; end
            ST_PASS:    begin rxd_o = ~dom_i; oe_o = 1'b1; end
            ST_BLANK:   begin rxd_o = 1'b1;   oe_o = 1'b1; end
        endcase
    end

    assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (!oe_o || !rxd_o));

    assert_awake_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> oe_o);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !rxd_o && sleep_i && $past(sleep_i)) |=> (oe_o && !rxd_o));

endmodule

// File: rtl/swrx_rx_cond.sv
module swrx_rx_cond #(
    parameter int unsigned MIN_PULSE_CYC = 8,
    parameter int unsigned BLANK_CYC     = 48,
    parameter int unsigned WAKE_FILT_CYC = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic tx_i,
    input  logic bus_dom_i,
    input  logic hv_dom_i,
    output logic rxd_o,
    output logic rxd_oe_o,
    output logic wake_o
);
    logic dom_filt;
    logic wake_filt;
    logic tx_rise;
    logic blank_last;

    swrx_glitch_filter #(.SETTLE_CYC(MIN_PULSE_CYC)) u_bus_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (bus_dom_i),
        .clean_o (dom_filt)
    );

    swrx_glitch_filter #(.SETTLE_CYC(WAKE_FILT_CYC)) u_wake_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (hv_dom_i),
        .clean_o (wake_filt)
    );

    swrx_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_i   (tx_i),
        .rise_o (tx_rise),
        .last_o (blank_last)
    );

    swrx_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .rise_i  (tx_rise),
        .last_i  (blank_last),
        .dom_i   (dom_filt),
        .wake_i  (wake_filt),
        .rxd_o   (rxd_o),
        .oe_o    (rxd_oe_o)
    );

    assign wake_o = wake_filt;

    assert_blank_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sleep_i) && !sleep_i && $rose(tx_i)) |=> rxd_o);

endmodule

// File: tb/swrx_rx_cond_test.sv
module swrx_rx_cond_test;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_P = 8;
    localparam int BLK   = 48;
    localparam int WAKE  = 640;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0;
    logic tx_i = 1'b1;
    logic bus_dom_i = 1'b0;
    logic hv_dom_i = 1'b0;
    logic rxd_o, rxd_oe_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic rxd;
        logic oe;
        logic wake;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    swrx_rx_cond #(
        .MIN_PULSE_CYC (MIN_P),
        .BLANK_CYC     (BLK),
        .WAKE_FILT_CYC (WAKE)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep_i),
        .tx_i      (tx_i),
        .bus_dom_i (bus_dom_i),
        .hv_dom_i  (hv_dom_i),
        .rxd_o     (rxd_o),
        .rxd_oe_o  (rxd_oe_o),
        .wake_o    (wake_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic rxd, input logic oe, input logic wk, input string req);
        exp_t e;
        e.rxd = rxd; e.oe = oe; e.wake = wk; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares the queued expectation shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (rxd_o !== e.rxd || rxd_oe_o !== e.oe || wake_o !== e.wake) begin
                    n_fail++;
                    $display("FAIL %s: actual rxd=%b oe=%b wake=%b expected rxd=%b oe=%b wake=%b",
                             e.req, rxd_o, rxd_oe_o, wake_o, e.rxd, e.oe, e.wake);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=still running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_out(1, 0, 0, "R10 reset");                  // R10
        rst_n = 1'b1;
        step(1);
        expect_out(1, 1, 0, "R9 awake after reset");       // R9

        // R1 R2: dominant run of exact length
        bus_dom_i = 1'b1;
        step(MIN_P - 1); expect_out(1, 1, 0, "R2 not yet");
        step(1);         expect_out(0, 1, 0, "R1 dominant");
        // R3: release edge filtered the same way
        bus_dom_i = 1'b0;
        step(MIN_P - 1); expect_out(0, 1, 0, "R3 not yet");
        step(1);         expect_out(1, 1, 0, "R1 recessive");
        // R2: short dominant pulse
        bus_dom_i = 1'b1;
        step(MIN_P - 1); bus_dom_i = 1'b0; expect_out(1, 1, 0, "R2 short pulse");
        step(MIN_P + 2); expect_out(1, 1, 0, "R2 short pulse ignored");
        // R3: short recessive gap
        bus_dom_i = 1'b1;
        step(MIN_P);     expect_out(0, 1, 0, "R1 dominant again");
        bus_dom_i = 1'b0;
        step(MIN_P - 1); bus_dom_i = 1'b1; expect_out(0, 1, 0, "R3 short gap");
        step(MIN_P + 2); expect_out(0, 1, 0, "R3 short gap ignored");

        // R4: release with bus still dominant
        tx_i = 1'b0; step(2);
        tx_i = 1'b1;
        step(1);       expect_out(1, 1, 0, "R4 blank start");
        step(BLK - 1); expect_out(1, 1, 0, "R4 blank last cycle");
        step(1);       expect_out(0, 1, 0, "R4 blank end");

        // R5: restart inside window
        tx_i = 1'b0; step(1);
        tx_i = 1'b1;
        step(20);      tx_i = 1'b0; expect_out(1, 1, 0, "R5 mid window");
        step(1);       tx_i = 1'b1;
        step(BLK);     expect_out(1, 1, 0, "R5 restarted window");
        step(1);       expect_out(0, 1, 0, "R5 restarted end");

        // R6: wake qualifier while awake
        hv_dom_i = 1'b1;
        step(WAKE - 1); expect_out(0, 1, 0, "R6 wake not yet");
        step(1);        expect_out(0, 1, 1, "R6 wake rise");
        hv_dom_i = 1'b0; bus_dom_i = 1'b0;
        step(WAKE - 1); expect_out(1, 1, 1, "R6 wake still high");
        step(1);        expect_out(1, 1, 0, "R6 wake fall");

        // R7: sleep gates traffic
        sleep_i = 1'b1;
        step(1);         expect_out(1, 0, 0, "R7 sleep entry");
        bus_dom_i = 1'b1;
        step(MIN_P + 5); expect_out(1, 0, 0, "R7 traffic ignored");
        bus_dom_i = 1'b0;
        // R6: short wake excursion in sleep
        hv_dom_i = 1'b1;
        step(WAKE - 1);  hv_dom_i = 1'b0; expect_out(1, 0, 0, "R6 short excursion");
        step(WAKE + 2);  expect_out(1, 0, 0, "R6 short excursion ignored");
        // R8: valid wake interrupt
        hv_dom_i = 1'b1; bus_dom_i = 1'b1;
        step(WAKE);      expect_out(1, 0, 1, "R8 wake qualified");
        step(1);         expect_out(0, 1, 1, "R8 interrupt low");
        hv_dom_i = 1'b0; bus_dom_i = 1'b0;
        step(WAKE + 5);  expect_out(0, 1, 0, "R8 interrupt held");
        sleep_i = 1'b0;
        step(1);         expect_out(1, 1, 0, "R9 resume");

        // R11: sleep during a window
        bus_dom_i = 1'b1;
        step(MIN_P);     expect_out(0, 1, 0, "R1 before R11");
        tx_i = 1'b0; step(1);
        tx_i = 1'b1;
        step(1);         expect_out(1, 1, 0, "R11 blanking");
        sleep_i = 1'b1;
        step(1);         expect_out(1, 0, 0, "R11 sleep wins");
        sleep_i = 1'b0;
        step(1);         expect_out(0, 1, 0, "R11 window dropped");

        step(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule